// File: doc/BRIEF.md
# Multichannel Edge-Programmed PWM Generator

This block drives several pulse-width-modulated outputs from one shared time base. A prescaler divides the input clock into steps, and a period counter counts those steps. Each channel holds two compare positions: one step where its output goes high and one step where it goes low. Duty cycle and phase are both set by where these two positions fall inside the period. To get inverted polarity, software swaps the two positions. To hold an output at a steady level, software programs one position with a value the counter never reaches.

A single write port loads every register. Edge writes can take effect at once, or they can be staged so that a whole set of edge changes lands together at the next period boundary. Only channels built with shadow storage can stage their writes. The number of such channels is fixed by a parameter, and the lowest-numbered channels are the ones that get it.

Each channel's level is a two-state machine. Its states are `LVL_LOW` and `LVL_HIGH`. The machine is evaluated once per step, in the first clock of that step. The transition `LVL_LOW -> LVL_HIGH` is taken on a rise match. The transition `LVL_HIGH -> LVL_LOW` is taken on a fall match. In every other case the machine stays in its current state.

Top module: `pwm_edge_gen`

## Requirements
- R1: Reset clears prescale, period, all edge values and the update control to 0. It drives every output low for as long as reset is held.
- R2: A prescaler counts 0..prescale, and the step counter counts 0..period, advancing once per prescaler wrap. The output period is therefore (prescale+1)*(period+1) clocks.
- R3: When the step count equals a channel's rise value, the output goes high. When it equals the fall value, the output goes low. A channel with rise r < fall f is high for (f-r) steps of each period. A channel with r > f is high for (period+1)-(r-f) steps.
- R4: If rise equals fall, the output inverts at that step in every period. It is therefore high for one full period, then low for one full period, and is never constant.
- R5: An edge value of period+1 is never matched, so that transition never happens. With period at most 0xFE, this gives a 0% or 100% level. With period 0xFF, the highest reachable duty is 255 of 256 steps.
- R6: Swapping the rise and fall values of a channel gives the complementary high time.
- R7: Write addresses are decoded as follows:
  - 0 loads prescale.
  - 1 loads period.
  - 2 loads the update control from data bit 0.
  - 4+2c loads the rise value of channel c.
  - 5+2c loads the fall value of channel c.
- R8: With the update control at 0, an edge write to any channel takes effect from the next step on.
- R9: With the update control at 1, edge writes to channels below index SHADOWED are held in shadow storage. They are copied to the active values on the clock where the step counter wraps to 0, and the active values do not change at any other time.
- R10: Channels at or above index SHADOWED ignore the update control. Their edge writes always take effect at once.
- R11: An output changes only on the clock after the first cycle of a step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address (R7) |
| wr_data | input | W | Register write data |
| pwm_out | output | NCH | One PWM output per channel |

## Verification
The hardest case to reach is a staged edge write that lands partway through a period. It must be held back on a shadowed channel, yet take hold at once on a plain channel. The stimulus gives both kinds of channel the same long period and the same edges. It waits for their rising edge and writes a new fall position to both before the old fall step arrives. It then samples both outputs between the new fall step and the old one. A second pass repeats the write with staging turned off to show the immediate path on a shadowed channel.

// File: rtl/pwm_edge_pkg.sv
package pwm_edge_pkg;
    // register addresses
    localparam int unsigned ADR_PRESCALE = 0;
    localparam int unsigned ADR_PERIOD   = 1;
    localparam int unsigned ADR_SYNC     = 2;
    localparam int unsigned ADR_CH_BASE  = 4;

    typedef enum logic {
        LVL_LOW  = 1'b0,
        LVL_HIGH = 1'b1
    } lvl_state_t;
endpackage

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] prescale,
    input  logic [W-1:0] period,
    output logic [W-1:0] pre_cnt,
    output logic [W-1:0] step_cnt,
    output logic         step_start,
    output logic         wrap
);
    logic pre_last;

    assign pre_last   = (pre_cnt >= prescale);
    assign step_start = (pre_cnt == '0);
    assign wrap       = pre_last && (step_cnt >= period);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_cnt  <= '0;
            step_cnt <= '0;
        end else if (pre_last) begin
            pre_cnt <= '0;
            if (step_cnt >= period) begin
                step_cnt <= '0;
            end else begin
                step_cnt <= step_cnt + 1'b1;
            end
        end else begin
            pre_cnt <= pre_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
    import pwm_edge_pkg::*;
#(
    parameter int unsigned W          = 8,
    parameter bit          HAS_SHADOW = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sync_en,
    input  logic         wr_rise,
    input  logic         wr_fall,
    input  logic [W-1:0] wr_data,
    input  logic         wrap,
    input  logic         step_start,
    input  logic [W-1:0] step_cnt,
    output logic [W-1:0] rise_act,
    output logic [W-1:0] fall_act,
    output logic         pwm
);
    lvl_state_t state_q, state_d;
    logic       rise_hit, fall_hit;

    generate
        if (HAS_SHADOW) begin : g_shadow
            logic [W-1:0] rise_sh, fall_sh, rise_sh_d, fall_sh_d;

            assign rise_sh_d = wr_rise ? wr_data : rise_sh;
            assign fall_sh_d = wr_fall ? wr_data : fall_sh;

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    rise_sh  <= '0;
                    fall_sh  <= '0;
                    rise_act <= '0;
                    fall_act <= '0;
                end else begin
                    rise_sh <= rise_sh_d;
                    fall_sh <= fall_sh_d;
                    if (sync_en) begin
                        if (wrap) begin
                            rise_act <= rise_sh_d;
                            fall_act <= fall_sh_d;
                        end
                    end else begin
                        if (wr_rise) rise_act <= wr_data;
                        if (wr_fall) fall_act <= wr_data;
                    end
                end
            end
        end else begin : g_direct
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    rise_act <= '0;
                    fall_act <= '0;
                end else begin
                    if (wr_rise) rise_act <= wr_data;
                    if (wr_fall) fall_act <= wr_data;
                end
            end
        end
    endgenerate

    assign rise_hit = step_start && (step_cnt == rise_act);
    assign fall_hit = step_start && (step_cnt == fall_act);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= LVL_LOW;
        end else begin
            state_q <= state_d;
        end
    end

    // next state and output
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LVL_LOW:  if (rise_hit) state_d = LVL_HIGH;
            LVL_HIGH: if (fall_hit) state_d = LVL_LOW;
            default:  state_d = LVL_LOW;
        endcase
        pwm = (state_q == LVL_HIGH);
    end
endmodule

// File: rtl/pwm_edge_gen.sv
module pwm_edge_gen
    import pwm_edge_pkg::*;
#(
    parameter int unsigned NCH      = 4,
    parameter int unsigned W        = 8,
    parameter int unsigned SHADOWED = 2,
    localparam int unsigned ADDR_W  = $clog2(ADR_CH_BASE + 2 * NCH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [W-1:0]      wr_data,
    output logic [NCH-1:0]    pwm_out
);
    logic [W-1:0]          prescale_q, period_q;
    logic                  sync_q;
    logic [W-1:0]          pre_cnt, step_cnt;
    logic                  step_start, wrap;
    logic [NCH-1:0][W-1:0] rise_act, fall_act;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prescale_q <= '0;
            period_q   <= '0;
            sync_q     <= 1'b0;
        end else if (wr_en) begin
            if (wr_addr == ADDR_W'(ADR_PRESCALE)) prescale_q <= wr_data;
            if (wr_addr == ADDR_W'(ADR_PERIOD))   period_q   <= wr_data;
            if (wr_addr == ADDR_W'(ADR_SYNC))     sync_q     <= wr_data[0];
        end
    end

    pwm_timebase #(.W(W)) u_timebase (
        .clk        (clk),
        .rst_n      (rst_n),
        .prescale   (prescale_q),
        .period     (period_q),
        .pre_cnt    (pre_cnt),
        .step_cnt   (step_cnt),
        .step_start (step_start),
        .wrap       (wrap)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic wr_r, wr_f;
        assign wr_r = wr_en && (wr_addr == ADDR_W'(ADR_CH_BASE + 2 * c));
        assign wr_f = wr_en && (wr_addr == ADDR_W'(ADR_CH_BASE + 2 * c + 1));

        pwm_channel #(.W(W), .HAS_SHADOW(c < SHADOWED)) u_ch (
            .clk        (clk),
            .rst_n      (rst_n),
            .sync_en    (sync_q),
            .wr_rise    (wr_r),
            .wr_fall    (wr_f),
            .wr_data    (wr_data),
            .wrap       (wrap),
            .step_start (step_start),
            .step_cnt   (step_cnt),
            .rise_act   (rise_act[c]),
            .fall_act   (fall_act[c]),
            .pwm        (pwm_out[c])
        );
    end
endmodule

// File: rtl/pwm_edge_gen_chk.sv
module pwm_edge_gen_chk #(
    parameter int unsigned NCH      = 4,
    parameter int unsigned W        = 8,
    parameter int unsigned SHADOWED = 2
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  step_start,
    input logic                  wrap,
    input logic                  sync_q,
    input logic [W-1:0]          pre_cnt,
    input logic [W-1:0]          step_cnt,
    input logic [W-1:0]          prescale_q,
    input logic [NCH-1:0][W-1:0] rise_act,
    input logic [NCH-1:0][W-1:0] fall_act,
    input logic [NCH-1:0]        pwm_out
);
    p_wrap_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> (step_cnt == '0) && (pre_cnt == '0));

    p_step_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_cnt < prescale_q) |=> $stable(step_cnt));

    for (genvar c = 0; c < NCH; c++) begin : g_c
        p_rise_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (step_start && step_cnt == rise_act[c] && step_cnt != fall_act[c])
            |=> pwm_out[c]);

        p_fall_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (step_start && step_cnt == fall_act[c] && step_cnt != rise_act[c])
            |=> !pwm_out[c]);

        p_both_flip_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (step_start && step_cnt == fall_act[c] && step_cnt == rise_act[c])
            |=> pwm_out[c] != $past(pwm_out[c]));

        p_no_match_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (step_start && step_cnt != fall_act[c] && step_cnt != rise_act[c])
            |=> $stable(pwm_out[c]));

        p_out_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
            !step_start |=> $stable(pwm_out[c]));

        if (c < SHADOWED) begin : g_sh
            p_shadow_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
                (sync_q && !wrap) |=> ($stable(rise_act[c]) && $stable(fall_act[c])));
        end
    end
endmodule

bind pwm_edge_gen pwm_edge_gen_chk #(.NCH(NCH), .W(W), .SHADOWED(SHADOWED)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .step_start (step_start),
    .wrap       (wrap),
    .sync_q     (sync_q),
    .pre_cnt    (pre_cnt),
    .step_cnt   (step_cnt),
    .prescale_q (prescale_q),
    .rise_act   (rise_act),
    .fall_act   (fall_act),
    .pwm_out    (pwm_out)
);

// File: tb/pwm_edge_gen_bench.sv
`timescale 1ns/1ps
module pwm_edge_gen_bench;
    localparam int NCH = 4;
    localparam int W   = 8;
    localparam int AW  = 4;

    typedef struct packed {
        logic [7:0]  pre;
        logic [7:0]  per;
        logic [7:0]  rise;
        logic [7:0]  fall;
        logic [15:0] hi2;   // expected high clocks over two periods
    } vec_t;

    // R3 R4 R5 R6 vectors
    localparam vec_t VECS [11] = '{
        '{8'd0, 8'd9,   8'd2,  8'd6,   16'd8},   // R3
        '{8'd1, 8'd9,   8'd2,  8'd6,   16'd16},  // R3 prescaled
        '{8'd3, 8'd4,   8'd1,  8'd3,   16'd16},  // R3
        '{8'd0, 8'd9,   8'd7,  8'd2,   16'd10},  // R3 wrap-around
        '{8'd0, 8'd9,   8'd0,  8'd10,  16'd20},  // R5 fall never
        '{8'd0, 8'd9,   8'd10, 8'd3,   16'd0},   // R5 rise never
        '{8'd0, 8'd9,   8'd4,  8'd4,   16'd10},  // R4 equal
        '{8'd2, 8'd5,   8'd0,  8'd3,   16'd18},  // R3
        '{8'd0, 8'd254, 8'd0,  8'd255, 16'd510}, // R5 full duty
        '{8'd0, 8'd255, 8'd0,  8'd255, 16'd510}, // R5 255 of 256
        '{8'd0, 8'd9,   8'd6,  8'd2,   16'd12}   // R6 swapped
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [W-1:0]  wr_data = '0;
    logic [NCH-1:0] pwm_out;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    pwm_edge_gen #(.NCH(NCH), .W(W), .SHADOWED(2)) u_pwm_edge_gen (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .pwm_out (pwm_out)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input int addr, input int data);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_addr = AW'(addr);
        wr_data = W'(data);
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic count_high(input int ch, input int n, output int hi);
        hi = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (pwm_out[ch]) hi++;
        end
    endtask

    task automatic wait_rise(input int ch);
        while (pwm_out[ch]) @(negedge clk);
        while (!pwm_out[ch]) @(negedge clk);
    endtask

    initial begin
        #800000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int hi, t, len;
        idle(3);
        check(pwm_out == '0, "R1 outputs low in reset", int'(pwm_out), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // table walk: channel 0 (shadow-capable, sync off) and channel 3 (plain)
        foreach (VECS[i]) begin
            wr(0, VECS[i].pre);
            wr(1, VECS[i].per);
            wr(4, VECS[i].rise);
            wr(5, VECS[i].fall);
            wr(10, VECS[i].rise);
            wr(11, VECS[i].fall);
            t = (int'(VECS[i].pre) + 1) * (int'(VECS[i].per) + 1);
            idle(3 * t);
            count_high(0, 2 * t, hi);
            check(hi == int'(VECS[i].hi2), $sformatf("R3/R4/R5/R6 vec%0d ch0", i), hi, int'(VECS[i].hi2));
            count_high(3, 2 * t, hi);
            check(hi == int'(VECS[i].hi2), $sformatf("R8 R10 vec%0d ch3", i), hi, int'(VECS[i].hi2));
        end

        // R2 period length
        wr(0, 2); wr(1, 4); wr(4, 0); wr(5, 2);
        idle(40);
        wait_rise(0);
        len = 0;
        while (pwm_out[0]) begin @(negedge clk); len++; end
        while (!pwm_out[0]) begin @(negedge clk); len++; end
        check(len == 15, "R2 period clocks", len, 15);

        // R7 unmapped address 3 leaves channel 0 untouched
        wr(3, 8'hFF);
        idle(30);
        count_high(0, 30, hi);
        check(hi == 12, "R7 addr3 ignored", hi, 12);

        // staged update: ch0 shadowed, ch2 plain
        wr(0, 0); wr(1, 99);
        wr(4, 0); wr(5, 50); wr(8, 0); wr(9, 50);
        idle(300);
        wr(2, 1);
        wait_rise(0);
        idle(3);
        wr(5, 20);
        wr(9, 20);
        idle(20);
        check(pwm_out[0] == 1'b1, "R9 shadowed edge held mid-period", int'(pwm_out[0]), 1);
        check(pwm_out[2] == 1'b0, "R10 plain channel takes write at once", int'(pwm_out[2]), 0);
        idle(100);
        count_high(0, 200, hi);
        check(hi == 40, "R9 staged value after wrap", hi, 40);

        // R8 sync off: shadow-capable channel takes write at once
        wr(2, 0);
        wait_rise(0);
        idle(3);
        wr(5, 60);
        idle(25);
        check(pwm_out[0] == 1'b1, "R8 immediate write ch0", int'(pwm_out[0]), 1);
        idle(100);
        count_high(0, 200, hi);
        check(hi == 120, "R8 new duty ch0", hi, 120);

        // R1 reset returns outputs low
        @(negedge clk);
        rst_n = 1'b0;
        idle(2);
        check(pwm_out == '0, "R1 outputs low after re-reset", int'(pwm_out), 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule